// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is a byte-wide SPI master. Software fills a transmit queue through a small register port, sets the run bit, and the engine shifts each queued byte out on the serial data output, most significant bit first. At the same time it collects the byte arriving on the serial data input into a receive queue. The serial clock comes from the core clock through an even divider. Any of the four clock polarity and phase combinations can be chosen, and one of the native select lines can be picked, each with its own active level. A read-enable bit turns the data output driver off for single-wire read phases. One interrupt output combines a "transfer drained" condition with an "RX queue nearly full" condition.

The register port has three word addresses. Address 0 is control and status, address 1 is the data queue (a write pushes to TX, a read pops from RX), and address 2 is the 16-bit divider. Reads are combinational on the address. Writes and queue pops take effect at the clock edge that sees the strobe.

Top module: `spi_master_top`

## Requirements
- R1: The serial clock half period is floor(DIV/2) core cycles, where DIV is the value at address 2. A DIV of 0 or 1 gives a half period of 32768 core cycles. The serial clock holds its level for a whole half period.
- R2: A byte occupies 18 half periods. The first 16 half periods carry the 8 data bits, most significant first, each bit held for two half periods. The last 2 half periods are an idle serial period at the idle level. Successive bytes are separated by two core cycles.
- R3: Control bit 3 (CPOL) sets the serial clock idle level. With control bit 2 (CPHA) clear, the first half period of each bit sits at the idle level. With it set, the first half period sits at the opposite level.
- R4: The input is sampled at the end of the first half period of each bit. The assembled byte enters the RX queue and is read at address 1 in arrival order, in bits 7:0.
- R5: Control bits 1:0 select a line. Values 0 and 1 drive select outputs 0 and 1. Values 2 and 3 drive none. Bits 21 and 22 give the active level of lines 0 and 1 (1 = active high). A line is active while control bit 7 (run) is set or a byte is in flight.
- R6: While the run bit is clear, no byte starts. Clearing it mid-byte lets that byte finish, and the select line is released only afterwards.
- R7: Status bits read at address 0 are as follows. Bit 16 is set when the run bit is set, the TX queue is empty and no byte is in flight. Bit 17 means the RX queue is not empty. Bit 18 means the TX queue has room. Bit 19 means the RX queue holds at least 12 of its 16 entries. Bit 20 means the RX queue is full.
- R8: Writing 1 to control bit 4 empties the TX queue, and writing 1 to bit 5 empties the RX queue. Both bits read back as 0.
- R9: The interrupt output is high when control bit 9 is set and status bit 16 is set, or when control bit 10 is set and status bit 19 is set.
- R10: With control bit 12 set, the data output enable is low. With it clear, the enable is high.
- R11: A write to the data address while the TX queue holds 16 bytes is ignored. No byte starts while the RX queue is full, so no received byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Word address: 0 control/status, 1 data, 2 divider |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops RX at address 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data driver |
| miso | input | 1 | Serial data in |
| sel | output | 2 | Native select lines |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that software leaves the divider and the clock polarity and phase unchanged while a byte is in flight, since the stable-clock and idle-level properties are written against fixed settings. The bench writes those fields only when the engine is quiet, or in the same write that sets the run bit. It drives the serial input on falling core edges from the model's bit position, so the value is settled at every sampling edge. The bench never pops an empty RX queue or pushes into a full TX queue in the same cycle as a clear. The full-queue cases are reached by filling the queues step by step.

// File: rtl/spi_eng_pkg.sv
// Shared constants and control-word layout for the SPI master engine.
// Assumes a 32-bit register port with three word addresses.
package spi_eng_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int B_CPHA   = 2;
    localparam int B_CPOL   = 3;
    localparam int B_CLRTX  = 4;
    localparam int B_CLRRX  = 5;
    localparam int B_RUN    = 7;
    localparam int B_IEDONE = 9;
    localparam int B_IERX   = 10;
    localparam int B_RDEN   = 12;
    localparam int B_DONE   = 16;
    localparam int B_RXNE   = 17;
    localparam int B_TXRM   = 18;
    localparam int B_RXHI   = 19;
    localparam int B_RXFL   = 20;
    localparam int B_LPOL0  = 21;

    typedef struct packed {
        logic [1:0] line_pol;
        logic       rden;
        logic       ie_rx;
        logic       ie_done;
        logic       run;
        logic       cpol;
        logic       cpha;
        logic [1:0] idx;
    } ctrl_t;
endpackage

// File: rtl/spi_byte_fifo.sv
// Synchronous queue with a registered count and a combinational head output.
// Assumes the caller ignores push when full and pop when empty; clear wins over both.
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Shifts one byte per start pulse: 16 data half periods then 2 idle ones.
// Assumes half_len, cpol and cpha stay constant while busy.
module spi_shift_engine #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    tx_byte,
    input  logic [HW-1:0] half_len,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic [7:0]    rx_byte,
    output logic          rx_done,
    output logic          half_edge
);
    localparam logic [4:0] DATA_HALVES = 5'd16;
    localparam logic [4:0] LAST_HALF   = 5'd17;

    logic [4:0]    hcnt;
    logic [HW-1:0] dcnt;
    logic [7:0]    sh_tx, sh_rx;

    assign half_edge = busy && (dcnt == half_len - 1'b1);
    assign sclk      = (busy && hcnt < DATA_HALVES) ? (cpol ^ cpha ^ hcnt[0]) : cpol;
    assign mosi      = sh_tx[7];
    assign rx_byte   = sh_rx;

    // Half-period timing, bit shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            hcnt    <= '0;
            dcnt    <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                hcnt  <= '0;
                dcnt  <= '0;
                sh_tx <= tx_byte;
            end else if (busy) begin
                if (half_edge) begin
                    dcnt <= '0;
                    if (hcnt < DATA_HALVES && !hcnt[0]) sh_rx <= {sh_rx[6:0], miso};
                    if (hcnt < DATA_HALVES && hcnt[0])  sh_tx <= {sh_tx[6:0], 1'b0};
                    if (hcnt == LAST_HALF) begin
                        busy    <= 1'b0;
                        rx_done <= 1'b1;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_master_top.sv
// SPI master: register port, TX/RX byte queues, divider, select lines, interrupt.
// Assumes software changes divider and clock mode only while the engine is quiet.
module spi_master_top
    import spi_eng_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_SEL    = 2,
    parameter int DIV_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    output logic        sdo_oe,
    input  logic        miso,
    output logic [1:0]  sel,
    output logic        irq
);
    localparam int CW     = $clog2(FIFO_DEPTH + 1);
    localparam int RX_THR = (FIFO_DEPTH * 3) / 4;

    ctrl_t              ctrl;
    logic [DIV_W-1:0]   cdiv, half_len;
    logic               wr_ctrl, clr_tx, clr_rx, tx_push, rx_pop;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic [7:0]         tx_head, rx_head, rx_byte;
    logic               busy, start, rx_done, half_edge, done, rx_high, active;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign clr_tx   = wr_ctrl && reg_wdata[B_CLRTX];
    assign clr_rx   = wr_ctrl && reg_wdata[B_CLRRX];
    assign tx_push  = reg_wr && (reg_addr == ADDR_DATA);
    assign rx_pop   = reg_rd && (reg_addr == ADDR_DATA);
    assign half_len = (cdiv[DIV_W-1:1] == '0) ? DIV_W'(1 << (DIV_W - 1))
                                              : DIV_W'(cdiv[DIV_W-1:1]);
    assign start    = ctrl.run && !tx_empty && !rx_full && !busy && !rx_done;
    assign done     = ctrl.run && tx_empty && !busy;
    assign rx_high  = (rx_cnt >= CW'(RX_THR));
    assign active   = ctrl.run || busy;
    assign irq      = (ctrl.ie_done && done) || (ctrl.ie_rx && rx_high);
    assign sdo_oe   = !ctrl.rden;

    // Control and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            cdiv <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.idx      <= reg_wdata[1:0];
                ctrl.cpha     <= reg_wdata[B_CPHA];
                ctrl.cpol     <= reg_wdata[B_CPOL];
                ctrl.run      <= reg_wdata[B_RUN];
                ctrl.ie_done  <= reg_wdata[B_IEDONE];
                ctrl.ie_rx    <= reg_wdata[B_IERX];
                ctrl.rden     <= reg_wdata[B_RDEN];
                ctrl.line_pol <= reg_wdata[B_LPOL0 +: 2];
            end
            if (reg_wr && reg_addr == ADDR_DIV) cdiv <= reg_wdata[DIV_W-1:0];
        end
    end

    // One output per native select line; higher indices drive none.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel[i] = (active && ctrl.idx == 2'(i)) ? ctrl.line_pol[i] : !ctrl.line_pol[i];
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[1:0]            = ctrl.idx;
                reg_rdata[B_CPHA]         = ctrl.cpha;
                reg_rdata[B_CPOL]         = ctrl.cpol;
                reg_rdata[B_RUN]          = ctrl.run;
                reg_rdata[B_IEDONE]       = ctrl.ie_done;
                reg_rdata[B_IERX]         = ctrl.ie_rx;
                reg_rdata[B_RDEN]         = ctrl.rden;
                reg_rdata[B_DONE]         = done;
                reg_rdata[B_RXNE]         = !rx_empty;
                reg_rdata[B_TXRM]         = !tx_full;
                reg_rdata[B_RXHI]         = rx_high;
                reg_rdata[B_RXFL]         = rx_full;
                reg_rdata[B_LPOL0 +: 2]   = ctrl.line_pol;
            end
            ADDR_DATA: reg_rdata[7:0]       = rx_head;
            ADDR_DIV:  reg_rdata[DIV_W-1:0] = cdiv;
            default:   reg_rdata            = '0;
        endcase
    end

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(start), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_done), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.HW(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_head), .half_len(half_len),
        .cpol(ctrl.cpol), .cpha(ctrl.cpha), .miso(miso), .busy(busy), .sclk(sclk),
        .mosi(mosi), .rx_byte(rx_byte), .rx_done(rx_done), .half_edge(half_edge)
    );
endmodule

// File: rtl/spi_master_chk.sv
// Temporal checks on the SPI master, attached to every instance by bind.
// Assumes clock mode and divider are not rewritten while a byte is in flight.
module spi_master_chk #(
    parameter int NUM_SEL = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               start,
    input logic               rx_full,
    input logic               sclk,
    input logic               cpol,
    input logic [NUM_SEL-1:0] sel,
    input logic [NUM_SEL-1:0] pol,
    input logic               done,
    input logic               run,
    input logic               half_edge
);
    p_hold_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(half_edge)) |-> $stable(sclk));

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    p_single_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(sel ^ pol)));

    p_no_start_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !start);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_no_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !start);
endmodule

bind spi_master_top spi_master_chk #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .rx_full(rx_full),
    .sclk(sclk), .cpol(ctrl.cpol), .sel(sel), .pol(ctrl.line_pol), .done(done),
    .run(ctrl.run), .half_edge(half_edge)
);

// File: tb/sim_spi_master_top.sv
// Bench: behavioural queue model of the SPI master, compared on every cycle.
module sim_spi_master_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, sdo_oe, irq;
    logic        miso = 1'b0;
    logic [1:0]  sel;

    always #4 clk = ~clk;

    spi_master_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .sdo_oe(sdo_oe), .miso(miso), .sel(sel), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] txq[$], rxq[$], slq[$];
    logic [7:0] next_sl = 8'h00;
    bit   m_busy, m_pend, m_run, m_cpol, m_cpha, m_ied, m_ier, m_rden;
    bit   [1:0] m_idx, m_pol;
    int   m_cnt, m_half = 32768;
    logic [7:0] m_cur, m_sl, m_rxb;

    function automatic int half_of(input int d);
        int h;
        h = (d & 16'hffff) >> 1;
        return (h == 0) ? 32768 : h;
    endfunction

    always @(posedge clk) begin : model
        bit st, tx_ok, rx_ok;
        if (!rst_n) begin
            txq.delete(); rxq.delete(); slq.delete();
            m_busy = 0; m_pend = 0; m_run = 0; m_cpol = 0; m_cpha = 0;
            m_ied = 0; m_ier = 0; m_rden = 0; m_idx = 0; m_pol = 0;
            m_cnt = 0; m_half = 32768;
        end else begin
            st    = m_run && txq.size() > 0 && rxq.size() < 16 && !m_busy && !m_pend;
            tx_ok = reg_wr && reg_addr == 2'd1 && txq.size() < 16;
            rx_ok = reg_rd && reg_addr == 2'd1 && rxq.size() > 0;
            if (rx_ok) void'(rxq.pop_front());
            if (m_pend) begin
                rxq.push_back(m_rxb);
                m_pend = 0;
            end
            if (m_busy) begin
                if (m_cnt == 18 * m_half - 1) begin
                    m_busy = 0; m_pend = 1; m_rxb = m_sl;
                end else m_cnt++;
            end
            if (st) begin
                m_busy = 1; m_cnt = 0;
                m_cur = txq.pop_front();
                m_sl  = (slq.size() > 0) ? slq.pop_front() : 8'h00;
            end
            if (tx_ok) begin
                txq.push_back(reg_wdata[7:0]);
                slq.push_back(next_sl);
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_idx = reg_wdata[1:0]; m_cpha = reg_wdata[2]; m_cpol = reg_wdata[3];
                m_run = reg_wdata[7]; m_ied = reg_wdata[9]; m_ier = reg_wdata[10];
                m_rden = reg_wdata[12]; m_pol = reg_wdata[22:21];
                if (reg_wdata[4]) begin txq.delete(); slq.delete(); end
                if (reg_wdata[5]) rxq.delete();
            end
            if (reg_wr && reg_addr == 2'd2) m_half = half_of(int'(reg_wdata[15:0]));
        end
    end

    function automatic logic [31:0] exp_status();
        logic [31:0] w;
        bit dn;
        dn = m_run && txq.size() == 0 && !m_busy;
        w = '0;
        w[1:0] = m_idx; w[2] = m_cpha; w[3] = m_cpol; w[7] = m_run;
        w[9] = m_ied; w[10] = m_ier; w[12] = m_rden;
        w[16] = dn; w[17] = rxq.size() > 0; w[18] = txq.size() < 16;
        w[19] = rxq.size() >= 12; w[20] = rxq.size() == 16; w[22:21] = m_pol;
        return w;
    endfunction

    // Per-cycle comparison, then drive the serial input for the next edge.
    always @(negedge clk) begin : compare
        int  k;
        bit  e_sclk, act;
        logic [31:0] st;
        if (rst_n && !finished) begin
            k = m_busy ? (m_cnt / m_half) : 0;
            e_sclk = (m_busy && k < 16) ? (m_cpol ^ m_cpha ^ k[0]) : m_cpol;
            chk("R1/R3", "sclk", sclk, e_sclk);
            if (m_busy && k < 16) chk("R2", "mosi", mosi, m_cur[7 - k / 2]);
            act = m_run || m_busy;
            for (int i = 0; i < 2; i++)
                chk("R5", "sel", sel[i], (act && m_idx == i) ? m_pol[i] : !m_pol[i]);
            st = exp_status();
            chk("R9", "irq", irq, (m_ied && st[16]) || (m_ier && st[19]));
            chk("R10", "sdo_oe", sdo_oe, !m_rden);
            if (reg_addr == 2'd0) chk("R7", "status word", reg_rdata, st);
            miso <= (m_busy && k < 16) ? m_sl[7 - k / 2] : 1'b0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic push(input logic [7:0] b, input logic [7:0] s);
        next_sl = s;
        wr(2'd1, {24'd0, b});
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        @(posedge clk); #2;
        reg_addr = 2'd1; reg_rd = 1'b1;
        @(negedge clk);
        chk(tag, "rx data", reg_rdata[7:0], exp);
        @(posedge clk); #2;
        reg_rd = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk);
        while (m_busy || m_pend || (m_run && txq.size() > 0 && rxq.size() < 16));
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        report();
    end

    localparam logic [31:0] RUN = 32'h80;

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset status", reg_rdata, 32'h0004_0000);
        chk("R5", "reset sel", sel, 2'b11);
        chk("R3", "reset sclk", sclk, 0);
        chk("R9", "reset irq", irq, 0);

        // R2/R4: mode 0, line 0 active low, three bytes
        wr(2'd2, 32'd4);
        push(8'hA5, 8'h5A); push(8'h3C, 8'hC3); push(8'hF0, 8'h0F);
        wr(2'd0, RUN);
        wait_quiet();
        chk("R7", "done after drain", reg_rdata[16], 1);
        pop_chk("R4", 8'h5A); pop_chk("R4", 8'hC3); pop_chk("R4", 8'h0F);

        // R3/R5: other modes on line 1 with active-high level
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h0040_000D);
        push(8'h96, 8'h69);
        wr(2'd0, 32'h0040_008D);
        wait_quiet();
        pop_chk("R4", 8'h69);
        wr(2'd0, 32'h0040_0005);
        push(8'h81, 8'h7E);
        wr(2'd0, 32'h0040_0085);
        wait_quiet();
        pop_chk("R3", 8'h7E);
        wr(2'd0, 32'h0020_0008);
        push(8'h42, 8'hBD);
        wr(2'd0, 32'h0020_0088);
        wait_quiet();
        pop_chk("R3", 8'hBD);

        // R6: stop mid-byte, the byte finishes, the next one waits
        wr(2'd0, 32'h0);
        push(8'h11, 8'h33); push(8'h22, 8'h44);
        wr(2'd0, RUN);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h0);
        chk("R6", "sel held until byte ends", sel[0], 0);
        wait_quiet();
        chk("R6", "rx not empty", reg_rdata[17], 1);
        chk("R6", "done low while stopped", reg_rdata[16], 0);
        pop_chk("R6", 8'h33);
        wr(2'd0, 32'h10);
        chk("R8", "clear bit reads 0", reg_rdata[4], 0);
        wr(2'd0, RUN);
        @(negedge clk);
        chk("R8", "tx emptied so done", reg_rdata[16], 1);

        // R11/R7/R9: fill TX, overfill, RX threshold and full
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd2);
        for (int i = 0; i < 16; i++) push(8'(i), 8'(8'hE0 + i));
        chk("R11", "tx room when full", reg_rdata[18], 0);
        push(8'hFF, 8'h99);
        wr(2'd0, RUN | 32'h400);
        wait_quiet();
        chk("R7", "rx full flag", reg_rdata[20], 1);
        chk("R9", "irq on rx level", irq, 1);
        push(8'h55, 8'hAA); push(8'h66, 8'hBB);
        repeat (60) @(negedge clk);
        chk("R11", "no start while rx full", sclk, 0);
        for (int i = 0; i < 16; i++) pop_chk("R11", 8'(8'hE0 + i));
        wait_quiet();
        wr(2'd0, RUN | 32'h20);
        @(negedge clk);
        chk("R8", "rx emptied", reg_rdata[17], 0);

        // R9: drain interrupt
        wr(2'd0, RUN | 32'h200);
        @(negedge clk);
        chk("R9", "irq on done", irq, 1);

        // R5: index 3 and 2 drive no line
        wr(2'd0, 32'h3);
        push(8'hC5, 8'h5C);
        wr(2'd0, RUN | 32'h3);
        repeat (8) @(negedge clk);
        chk("R5", "idx3 no line", sel, 2'b11);
        wait_quiet();
        pop_chk("R5", 8'h5C);
        wr(2'd0, RUN | 32'h2);
        @(negedge clk);
        chk("R5", "idx2 no line", sel, 2'b11);

        // R10: read enable
        wr(2'd0, RUN | 32'h1000);
        @(negedge clk);
        chk("R10", "oe off", sdo_oe, 0);

        // R1: odd divider acts as even one
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd3);
        push(8'h3A, 8'hA3);
        wr(2'd0, RUN);
        wait_quiet();
        pop_chk("R1", 8'hA3);

        // R1: zero divider gives 32768-cycle half period
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd0);
        push(8'h80, 8'h00);
        wr(2'd0, RUN);
        repeat (20000) @(negedge clk);
        chk("R1", "sclk mid first half", sclk, 0);
        do @(negedge clk); while (m_cnt < 32770);
        chk("R1", "sclk second half", sclk, 1);
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "sclk after reset", sclk, 0);

        report();
    end
endmodule